// File: doc/BRIEF.md
# Staged Reset Release Sequencer

This block turns one power-good signal and one hard-reset request into a set of active-low reset outputs that are let go one after another. Every release is timed by a single counter in the main system clock domain. The counter starts when two conditions both hold: the hard-reset request has been withdrawn, and power-good has stayed high for a qualification window. Each output is released when the counter reaches that output's own offset. The offsets cover three downstream resets:

- a slow local-bus reset, whose delay is given in local-bus clock periods and converted to system clocks;
- a secondary-domain reset released after about four thousand clocks;
- a processor reset held for a very long time.

A bus-throttle flag stays raised from reset until a window closes. The window is either full length or half length, selected by a strap that is sampled when counting starts. A completion flag rises once every reset is released, the throttle window has closed, and the handshake window that follows the secondary-domain release has passed.

The power-good and hard-reset inputs are asynchronous and pass through two-flop synchronizers. If power-good drops or the hard-reset request returns, all outputs go back to their reset values within three clock edges. The sequence then starts again from the beginning.

Top module: `reset_release_seq`

## Requirements
- R1: While `rst` is high and on the first edges after it, `lbus_rst_n`, `sec_rst_n`, `cpu_rst_n` and `seq_done` are 0 and `bus_throttle` is 1.
- R2: With power-good already qualified, when `hard_rst_n` goes from 0 to 1 (1 means released), each reset output goes to 1 on the (D+3)th rising edge after the change. D is LBUS_CYC*LBUS_RATIO for `lbus_rst_n`, SEC_DLY for `sec_rst_n` and CPU_DLY for `cpu_rst_n`. The 3 comes from two synchronizer stages and one output register.
- R3: Power-good (`pwr_good`, 1 = good) must stay high for PG_DLY cycles before counting may begin. If `hard_rst_n` is already 1 when `pwr_good` rises, every offset in R2 and R4 grows by PG_DLY.
- R4: `bus_throttle` goes to 0 on the (L+3)th edge after the release. L is THR_HALF when `half_throttle` was 1 at the start of counting, and THR_FULL when it was 0.
- R5: Changing `half_throttle` after counting has started has no effect on when `bus_throttle` falls.
- R6: If `pwr_good` goes to 0 or `hard_rst_n` goes to 0, then by the third rising edge all reset outputs and `seq_done` are 0 and `bus_throttle` is 1. The next release is timed from zero again.
- R7: Once released, a reset output stays at 1 until the next event described in R6.
- R8: `seq_done` rises on the (M+3)th edge after the release. M is the largest of the three reset offsets, SEC_DLY+HS_CYC*HS_RATIO, and the selected throttle length L.
- R9: A dip of `pwr_good` to 0 during qualification restarts the PG_DLY window from the next rise.
- R10: When the offsets are ordered as in the defaults, the local-bus reset is released no later than the secondary reset, and the secondary reset no later than the processor reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main system clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| pwr_good | input | 1 | Asynchronous power-good, 1 = supplies good |
| hard_rst_n | input | 1 | Asynchronous hard-reset request, 0 = held in reset |
| half_throttle | input | 1 | Strap: 1 selects the half-length throttle window |
| lbus_rst_n | output | 1 | Local-bus reset, active low |
| sec_rst_n | output | 1 | Secondary-domain reset, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| bus_throttle | output | 1 | 1 while bus throttling is in force |
| seq_done | output | 1 | 1 once every release and window is complete |

## Verification
The bench targets the case where power-good arrives after the hard-reset release, including a power-good dip during qualification. A design that did not restart the window would release its resets early. It flips the throttle strap after counting starts, which exposes a design that keeps sampling the strap because the throttle would end at the wrong length. It aborts a sequence halfway and then runs it again, so a counter that is not cleared on abort shows up as early releases in the rerun. Random sequences mix the order of the two inputs, the throttle mode and which input causes the drop.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  function automatic int unsigned rsq_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rsq_timebase.sv
module rsq_timebase #(
  parameter int unsigned PG_DLY  = 16,
  parameter int unsigned CNT_MAX = 255,
  parameter int          CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pg_s,
  input  logic             hr_rel_s,
  output logic             active,
  output logic [CNT_W-1:0] cnt
);
  localparam int PGW = (PG_DLY < 1) ? 1 : $clog2(PG_DLY + 1);
  localparam logic [PGW-1:0]   PG_END = PGW'(PG_DLY);
  localparam logic [CNT_W-1:0] C_END  = CNT_W'(CNT_MAX);

  logic [PGW-1:0] pg_cnt;
  logic           pg_ready;

  // power-good qualification window, restarted by any dip
  always_ff @(posedge clk) begin
    if (rst)                  pg_cnt <= '0;
    else if (!pg_s)           pg_cnt <= '0;
    else if (pg_cnt != PG_END) pg_cnt <= pg_cnt + 1'b1;
  end

  assign pg_ready = (pg_cnt == PG_END);
  assign active   = pg_s && pg_ready && hr_rel_s;

  // shared release counter, saturating at the last needed value
  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (!active)       cnt <= '0;
    else if (cnt != C_END)  cnt <= cnt + 1'b1;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && ($past(cnt) != C_END)) |-> (cnt == $past(cnt) + 1'b1));

  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> (cnt == '0));
endmodule

// File: rtl/rsq_stage.sv
module rsq_stage #(
  parameter int CNT_W   = 8,
  parameter bit RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] thresh,
  output logic             out
);
  always_ff @(posedge clk) begin
    if (rst)                         out <= RST_VAL;
    else if (en && (cnt >= thresh))  out <= ~RST_VAL;
    else                             out <= RST_VAL;
  end

  assert_stays_released_R7: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && ($past(out) != RST_VAL)) |-> (out != RST_VAL));
endmodule

// File: rtl/reset_release_seq.sv
module reset_release_seq
  import rsq_pkg::*;
#(
  parameter int unsigned PG_DLY     = 300000,
  parameter int unsigned LBUS_CYC   = 4,
  parameter int unsigned LBUS_RATIO = 6,
  parameter int unsigned SEC_DLY    = 4004,
  parameter int unsigned HS_CYC     = 20,
  parameter int unsigned HS_RATIO   = 3,
  parameter int unsigned CPU_DLY    = 200000,
  parameter int unsigned THR_FULL   = 3000,
  parameter int unsigned THR_HALF   = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic hard_rst_n,
  input  logic half_throttle,
  output logic lbus_rst_n,
  output logic sec_rst_n,
  output logic cpu_rst_n,
  output logic bus_throttle,
  output logic seq_done
);
  localparam int unsigned LBUS_DLY  = LBUS_CYC * LBUS_RATIO;
  localparam int unsigned HS_END    = SEC_DLY + HS_CYC * HS_RATIO;
  localparam int unsigned REL_MAX   = rsq_max(CPU_DLY, rsq_max(HS_END, LBUS_DLY));
  localparam int unsigned DONE_FULL = rsq_max(REL_MAX, THR_FULL);
  localparam int unsigned DONE_HALF = rsq_max(REL_MAX, THR_HALF);
  localparam int unsigned CNT_MAX   = rsq_max(DONE_FULL, DONE_HALF);
  localparam int          CNT_W     = $clog2(CNT_MAX + 1);
  localparam int          N_REL     = 3;
  localparam int unsigned REL_DLY [N_REL] = '{LBUS_DLY, SEC_DLY, CPU_DLY};

  logic [1:0]       sync_q;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             mode_q;
  logic [CNT_W-1:0] thr_len;
  logic [CNT_W-1:0] done_th;
  logic [N_REL-1:0] rel_q;

  rsq_sync #(.W(2), .RST_VAL(2'b00)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pwr_good, hard_rst_n}),
    .q   (sync_q)
  );

  rsq_timebase #(.PG_DLY(PG_DLY), .CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_tb (
    .clk      (clk),
    .rst      (rst),
    .pg_s     (sync_q[1]),
    .hr_rel_s (sync_q[0]),
    .active   (active),
    .cnt      (cnt)
  );

  // throttle strap follows the pin until counting starts, then is frozen
  always_ff @(posedge clk) begin
    if (rst)          mode_q <= 1'b0;
    else if (!active) mode_q <= half_throttle;
  end

  assign thr_len = mode_q ? CNT_W'(THR_HALF)  : CNT_W'(THR_FULL);
  assign done_th = mode_q ? CNT_W'(DONE_HALF) : CNT_W'(DONE_FULL);

  generate
    for (genvar g = 0; g < N_REL; g++) begin : g_rel
      rsq_stage #(.CNT_W(CNT_W), .RST_VAL(1'b0)) u_rel (
        .clk    (clk),
        .rst    (rst),
        .en     (active),
        .cnt    (cnt),
        .thresh (CNT_W'(REL_DLY[g])),
        .out    (rel_q[g])
      );
    end
  endgenerate

  rsq_stage #(.CNT_W(CNT_W), .RST_VAL(1'b1)) u_thr (
    .clk    (clk),
    .rst    (rst),
    .en     (active),
    .cnt    (cnt),
    .thresh (thr_len),
    .out    (bus_throttle)
  );

  rsq_stage #(.CNT_W(CNT_W), .RST_VAL(1'b0)) u_done (
    .clk    (clk),
    .rst    (rst),
    .en     (active),
    .cnt    (cnt),
    .thresh (done_th),
    .out    (seq_done)
  );

  assign lbus_rst_n = rel_q[0];
  assign sec_rst_n  = rel_q[1];
  assign cpu_rst_n  = rel_q[2];

  assert_drop_all_R6: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!lbus_rst_n && !sec_rst_n && !cpu_rst_n && bus_throttle && !seq_done));

  assert_done_implies_R8: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> (lbus_rst_n && sec_rst_n && cpu_rst_n && !bus_throttle));

  generate
    if (CPU_DLY >= SEC_DLY) begin : g_ord_cpu
      assert_order_cpu_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_rst_n |-> sec_rst_n);
    end
    if (SEC_DLY >= LBUS_DLY) begin : g_ord_sec
      assert_order_sec_R10: assert property (@(posedge clk) disable iff (rst)
        sec_rst_n |-> lbus_rst_n);
    end
  endgenerate
endmodule

// File: tb/tb_reset_release_seq.sv
module tb_reset_release_seq;
  localparam int PG_DLY = 40, LBUS_CYC = 4, LBUS_RATIO = 6, SEC_DLY = 400;
  localparam int HS_CYC = 18, HS_RATIO = 3, CPU_DLY = 900;
  localparam int THR_FULL = 1000, THR_HALF = 300;
  localparam int LB_DLY = LBUS_CYC * LBUS_RATIO;

  logic clk = 1'b0, rst = 1'b1;
  logic pwr_good = 1'b0, hard_rst_n = 1'b0, half_throttle = 1'b0;
  logic lbus_rst_n, sec_rst_n, cpu_rst_n, bus_throttle, seq_done;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  reset_release_seq #(
    .PG_DLY(PG_DLY), .LBUS_CYC(LBUS_CYC), .LBUS_RATIO(LBUS_RATIO), .SEC_DLY(SEC_DLY),
    .HS_CYC(HS_CYC), .HS_RATIO(HS_RATIO), .CPU_DLY(CPU_DLY),
    .THR_FULL(THR_FULL), .THR_HALF(THR_HALF)
  ) dut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .hard_rst_n(hard_rst_n),
    .half_throttle(half_throttle), .lbus_rst_n(lbus_rst_n), .sec_rst_n(sec_rst_n),
    .cpu_rst_n(cpu_rst_n), .bus_throttle(bus_throttle), .seq_done(seq_done)
  );

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int exp_done(input int len);
    return imax(imax(CPU_DLY, SEC_DLY + HS_CYC * HS_RATIO), imax(LB_DLY, len));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input bit pg_last, input bit half, input bit flip, input bit glitch);
    int base, len, lim, t_lb, t_sec, t_cpu, t_thr, t_done;
    bit broke;
    half_throttle = half;
    pwr_good = 1'b0;
    hard_rst_n = 1'b0;
    repeat (5) @(negedge clk);
    if (pg_last) begin
      hard_rst_n = 1'b1;
      repeat (7) @(negedge clk);
      if (glitch) begin
        pwr_good = 1'b1;
        repeat (10) @(negedge clk);
        pwr_good = 1'b0;
        repeat (3) @(negedge clk);
      end
      pwr_good = 1'b1;
      base = PG_DLY;
    end else begin
      pwr_good = 1'b1;
      repeat (PG_DLY + 8) @(negedge clk);
      hard_rst_n = 1'b1;
      base = 0;
    end
    len = half ? THR_HALF : THR_FULL;
    t_lb = -1; t_sec = -1; t_cpu = -1; t_thr = -1; t_done = -1; broke = 1'b0;
    lim = base + exp_done(len) + 8;
    for (int k = 1; k <= lim; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (lbus_rst_n && t_lb < 0) t_lb = k; else if (!lbus_rst_n && t_lb >= 0) broke = 1'b1;
      if (sec_rst_n && t_sec < 0) t_sec = k; else if (!sec_rst_n && t_sec >= 0) broke = 1'b1;
      if (cpu_rst_n && t_cpu < 0) t_cpu = k; else if (!cpu_rst_n && t_cpu >= 0) broke = 1'b1;
      if (!bus_throttle && t_thr < 0) t_thr = k;
      if (seq_done && t_done < 0) t_done = k;
      if (flip && k == base + 5) half_throttle = ~half_throttle;
    end
    // R2 / R3 / R9 release edges
    chk(t_lb == base + LB_DLY + 3, pg_last ? "R3 lbus" : "R2 lbus", t_lb, base + LB_DLY + 3);
    chk(t_sec == base + SEC_DLY + 3, pg_last ? "R3 sec" : "R2 sec", t_sec, base + SEC_DLY + 3);
    chk(t_cpu == base + CPU_DLY + 3, glitch ? "R9 cpu" : "R2 cpu", t_cpu, base + CPU_DLY + 3);
    // R4 / R5 throttle window
    chk(t_thr == base + len + 3, flip ? "R5 throttle" : "R4 throttle", t_thr, base + len + 3);
    // R8 completion
    chk(t_done == base + exp_done(len) + 3, "R8 done", t_done, base + exp_done(len) + 3);
    // R7 monotonic, R10 ordering
    chk(!broke, "R7 stays released", broke, 0);
    chk(t_lb <= t_sec && t_sec <= t_cpu, "R10 order", t_cpu, t_sec);
  endtask

  task automatic drop_check(input bit use_pg);
    if (use_pg) pwr_good = 1'b0; else hard_rst_n = 1'b0;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk(!lbus_rst_n && !sec_rst_n && !cpu_rst_n, "R6 resets low",
        {lbus_rst_n, sec_rst_n, cpu_rst_n}, 0);
    chk(bus_throttle && !seq_done, "R6 throttle/done", {bus_throttle, seq_done}, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!lbus_rst_n && !sec_rst_n && !cpu_rst_n && !seq_done && bus_throttle, "R1 in reset",
        {lbus_rst_n, sec_rst_n, cpu_rst_n, seq_done, bus_throttle}, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!lbus_rst_n && !sec_rst_n && !cpu_rst_n && !seq_done && bus_throttle, "R1 after reset",
        {lbus_rst_n, sec_rst_n, cpu_rst_n, seq_done, bus_throttle}, 1);

    // directed: hard reset last, full window
    run_seq(1'b0, 1'b0, 1'b0, 1'b0);
    drop_check(1'b1);
    // directed: power-good last with a dip during qualification (R9), half window
    run_seq(1'b1, 1'b1, 1'b0, 1'b1);
    drop_check(1'b0);
    // directed: strap flipped after start (R5)
    run_seq(1'b0, 1'b1, 1'b1, 1'b0);
    drop_check(1'b1);

    // directed: abort mid-sequence, then full rerun must be timed afresh (R6)
    pwr_good = 1'b1;
    hard_rst_n = 1'b0;
    repeat (PG_DLY + 8) @(negedge clk);
    hard_rst_n = 1'b1;
    repeat (200) @(negedge clk);
    chk(lbus_rst_n && !cpu_rst_n, "R6 partial before abort", {lbus_rst_n, cpu_rst_n}, 2);
    drop_check(1'b0);
    run_seq(1'b0, 1'b0, 1'b0, 1'b0);

    // constrained random sequences
    for (int i = 0; i < 6; i++) begin
      bit pl, hf, fl, gl;
      pl = 1'($urandom_range(0, 1));
      hf = 1'($urandom_range(0, 1));
      fl = 1'($urandom_range(0, 1));
      gl = pl & 1'($urandom_range(0, 1));
      run_seq(pl, hf, fl, gl);
      drop_check(1'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule